// File: doc/BRIEF.md
# Block-Gap Pause and Resume Sequencer

This block follows a multi-block SD card data transfer from start to completion and decides when the transfer may be paused. Software asks for a pause by setting a stop request. The sequencer does not cut a block short. It waits for the end of the current block and only then stops the data path. When the transfer is a write, it parks in a plain gap pause. When the transfer is a read, a pause is possible only if the card can hold off its data, so the sequencer enters a read-wait period and drives a read-wait control line for as long as the pause lasts. If read wait is disabled, the stop request is ignored during a read.

A continue request resumes a paused transfer, but only while the stop request is clear. After the resume, the sequencer watches for the DAT line or the write path to become active again. When either one does, it emits a single-cycle pulse that tells the register file to clear the continue bit. The sequencer also opens a window for interrupt detection at each block gap, and it does this only when the bus is in 4-bit mode and the interrupt-at-gap bit is set. If the data port is written while the stop request is set, an error pulse is raised. A transfer-done event ends the sequence from any active state.

Top module: `blkgap_seq`

## Requirements
- R1: Reset state: after reset, `seq_state` reads 0, which is the idle code. `run`, `hold`, `rw_drive`, `cont_clr`, `gap_win` and `dport_err` all read 0. The state codes are idle=0, transfer=1, gap pause=2, read wait=3 and done=4.
- R2: In idle, a `xfer_start` pulse moves `seq_state` to 1 on the next clock edge, with `run`=1. The `xfer_dir` value seen with the start pulse is kept for the whole transfer, where 1 means read and 0 means write.
- R3: In the transfer state, `stop_req` has no effect until `blk_done` is seen. The state stays 1 for every cycle in which no block ends.
- R4: For a write transfer, `blk_done` together with `stop_req`=1 moves the state to 2 on the next edge, with `hold`=1, `run`=0 and `rw_drive`=0.
- R5: For a read transfer with `rdwait_en`=1, `blk_done` together with `stop_req`=1 moves the state to 3 on the next edge, with `hold`=1 and `rw_drive`=1.
- R6: For a read transfer with `rdwait_en`=0, a stop request is ignored at the block gap and the state stays 1.
- R7: In state 2 or 3, `cont_req`=1 with `stop_req`=0 returns the state to 1 on the next edge and clears `rw_drive`. If `stop_req`=1, `cont_req` is ignored and the pause continues.
- R8: After a resume, `cont_clr` pulses high for exactly one cycle. The pulse comes ACT_SYNC+1 clock edges after `dat_active` or `wr_active` goes high (ACT_SYNC defaults to 2). It pulses only once per resume.
- R9: When `gapirq_en`=1 and `wide_bus`=1, a `blk_done` in the transfer state opens `gap_win` for GAP_WIN_CYC cycles (default 4), starting the cycle after the event. `gap_win` also stays high for as long as the state is 2 or 3. If either enable is 0, `gap_win` stays 0.
- R10: A `dport_wr` while `stop_req`=1 raises `dport_err` for exactly one cycle on the next edge. A `dport_wr` with `stop_req`=0 raises nothing.
- R11: `xfer_done` in any non-idle state moves the state to 4 (done) on the next edge, taking priority over `blk_done`. From state 4 the sequencer returns to 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Pulse: a data transfer begins |
| xfer_dir | input | 1 | Direction captured at start, 1 = read |
| stop_req | input | 1 | Stop-at-gap control bit |
| cont_req | input | 1 | Continue control bit |
| rdwait_en | input | 1 | Read-wait control enable |
| gapirq_en | input | 1 | Interrupt-at-gap enable |
| wide_bus | input | 1 | 1 = 4-bit data bus |
| blk_done | input | 1 | Pulse: current block finished |
| xfer_done | input | 1 | Pulse: whole transfer complete |
| dat_active | input | 1 | DAT line active status |
| wr_active | input | 1 | Write transfer active status |
| dport_wr | input | 1 | Data-port write strobe |
| seq_state | output | 3 | Sequencer state code |
| run | output | 1 | Data movement allowed |
| hold | output | 1 | Transfer paused at a gap |
| rw_drive | output | 1 | Read-wait drive to the card |
| cont_clr | output | 1 | One-cycle clear for the continue bit |
| gap_win | output | 1 | Gap interrupt detection window |
| dport_err | output | 1 | One-cycle data-port misuse flag |

## Verification
The embedded properties check on every cycle that a transfer never pauses without a block end, that a read without read wait never pauses, and that a pause persists while the stop request is held. They also check that transfer-done always lands in the done state, that the continue-clear and error pulses last a single cycle, that the error pulse always follows a write made under a stop request, and that the gap counter stays within range. Only the directed scenarios can show the exact latency of the continue-clear after activity, the length of the gap window, the correct choice between gap pause and read wait by direction, and the reset values.

// File: rtl/blkgap_pkg.sv
package blkgap_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_XFER  = 3'd1,
      ST_GAP   = 3'd2,
      ST_RWAIT = 3'd3,
      ST_DONE  = 3'd4
   } seq_st_t;

   localparam int ACT_W = 2;
endpackage

// File: rtl/blkgap_sync.sv
module blkgap_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("blkgap_sync: STAGES out of range");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh[0] <= '0;
         else        sh[0] <= d;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= '0;
            else        sh[i] <= sh[i-1];
         end
      end
      assign q = sh[STAGES-1];
   end
endmodule

// File: rtl/blkgap_fsm.sv
module blkgap_fsm
   import blkgap_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    xfer_start,
   input  logic    xfer_dir,
   input  logic    stop_req,
   input  logic    cont_req,
   input  logic    rdwait_en,
   input  logic    blk_done,
   input  logic    xfer_done,
   input  logic    act_seen,
   output seq_st_t st,
   output logic    cont_clr
);
   seq_st_t st_nx;
   logic    dir_q;
   logic    armed;
   logic    resume;

   always_comb begin
      st_nx  = st;
      resume = 1'b0;
      if (xfer_done && st != ST_IDLE) begin
         st_nx = ST_DONE;
      end else begin
         unique case (st)
            ST_IDLE:  if (xfer_start) st_nx = ST_XFER;
            ST_XFER: begin
               if (blk_done && stop_req) begin
                  if (!dir_q)         st_nx = ST_GAP;
                  else if (rdwait_en) st_nx = ST_RWAIT;
               end
            end
            ST_GAP, ST_RWAIT: begin
               if (cont_req && !stop_req) begin
                  st_nx  = ST_XFER;
                  resume = 1'b1;
               end
            end
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         dir_q    <= 1'b0;
         armed    <= 1'b0;
         cont_clr <= 1'b0;
      end else begin
         st       <= st_nx;
         cont_clr <= 1'b0;
         if (st == ST_IDLE && xfer_start) dir_q <= xfer_dir;
         if (xfer_done) begin
            armed <= 1'b0;
         end else if (resume) begin
            armed <= 1'b1;
         end else if (armed && st == ST_XFER && act_seen) begin
            armed    <= 1'b0;
            cont_clr <= 1'b1;
         end
      end
   end

   AST_NO_MIDBLOCK_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_XFER && !blk_done && !xfer_done) |=> (st != ST_GAP && st != ST_RWAIT)); // R3
   AST_READ_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_XFER && dir_q && !rdwait_en && !xfer_done) |=> (st == ST_XFER)); // R6
   AST_PAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_GAP || st == ST_RWAIT) && stop_req && !xfer_done) |=> $stable(st)); // R7
   AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && st != ST_IDLE) |=> (st == ST_DONE)); // R11
   AST_CLR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      cont_clr |=> !cont_clr); // R8
endmodule

// File: rtl/blkgap_gapwin.sv
module blkgap_gapwin #(
   parameter int GAP_WIN_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gapirq_en,
   input  logic wide_bus,
   input  logic gap_evt,
   input  logic paused,
   input  logic kill,
   output logic gap_win
);
   localparam int CW = $clog2(GAP_WIN_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(GAP_WIN_CYC);

   if (GAP_WIN_CYC < 1) begin : g_bad_win
      $error("blkgap_gapwin: GAP_WIN_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (kill)            cnt <= '0;
      else if (gap_evt)         cnt <= LOAD;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign gap_win = gapirq_en && wide_bus && ((cnt != '0) || paused);

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOAD); // R9
endmodule

// File: rtl/blkgap_seq.sv
module blkgap_seq
   import blkgap_pkg::*;
#(
   parameter int ACT_SYNC    = 2,
   parameter int GAP_WIN_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xfer_start,
   input  logic       xfer_dir,
   input  logic       stop_req,
   input  logic       cont_req,
   input  logic       rdwait_en,
   input  logic       gapirq_en,
   input  logic       wide_bus,
   input  logic       blk_done,
   input  logic       xfer_done,
   input  logic       dat_active,
   input  logic       wr_active,
   input  logic       dport_wr,
   output logic [2:0] seq_state,
   output logic       run,
   output logic       hold,
   output logic       rw_drive,
   output logic       cont_clr,
   output logic       gap_win,
   output logic       dport_err
);
   seq_st_t          st;
   logic [ACT_W-1:0] act_q;
   logic             err_q;

   blkgap_sync #(.STAGES(ACT_SYNC), .W(ACT_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({wr_active, dat_active}),
      .q     (act_q)
   );

   blkgap_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_start (xfer_start),
      .xfer_dir   (xfer_dir),
      .stop_req   (stop_req),
      .cont_req   (cont_req),
      .rdwait_en  (rdwait_en),
      .blk_done   (blk_done),
      .xfer_done  (xfer_done),
      .act_seen   (|act_q),
      .st         (st),
      .cont_clr   (cont_clr)
   );

   blkgap_gapwin #(.GAP_WIN_CYC(GAP_WIN_CYC)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .gapirq_en (gapirq_en),
      .wide_bus  (wide_bus),
      .gap_evt   (blk_done && st == ST_XFER && !xfer_done),
      .paused    (hold),
      .kill      (xfer_done),
      .gap_win   (gap_win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= dport_wr && stop_req;
   end

   assign seq_state = st;
   assign run       = (st == ST_XFER);
   assign hold      = (st == ST_GAP) || (st == ST_RWAIT);
   assign rw_drive  = (st == ST_RWAIT);
   assign dport_err = err_q;

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      dport_err |-> $past(dport_wr && stop_req)); // R10
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (dport_err && !(dport_wr && stop_req)) |=> !dport_err); // R10
   AST_RW_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rw_drive |-> (hold && !run)); // R5
endmodule

// File: tb/sim_blkgap_seq.sv
`timescale 1ns/1ps
module sim_blkgap_seq;
   localparam int SYNC = 2;
   localparam int WIN  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xfer_start = 0, xfer_dir = 0, stop_req = 0, cont_req = 0;
   logic rdwait_en = 0, gapirq_en = 0, wide_bus = 0, blk_done = 0;
   logic xfer_done = 0, dat_active = 0, wr_active = 0, dport_wr = 0;
   logic [2:0] seq_state;
   logic run, hold, rw_drive, cont_clr, gap_win, dport_err;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   blkgap_seq #(.ACT_SYNC(SYNC), .GAP_WIN_CYC(WIN)) u0 (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
      .stop_req(stop_req), .cont_req(cont_req), .rdwait_en(rdwait_en),
      .gapirq_en(gapirq_en), .wide_bus(wide_bus), .blk_done(blk_done),
      .xfer_done(xfer_done), .dat_active(dat_active), .wr_active(wr_active),
      .dport_wr(dport_wr), .seq_state(seq_state), .run(run), .hold(hold),
      .rw_drive(rw_drive), .cont_clr(cont_clr), .gap_win(gap_win),
      .dport_err(dport_err)
   );

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_xfer(logic dir);
      xfer_dir = dir; xfer_start = 1; step(); xfer_start = 0;
   endtask

   task automatic finish_xfer();
      xfer_done = 1; step(); xfer_done = 0;
      chk("R11 done state", seq_state, 4);
      step();
      chk("R11 back to idle", seq_state, 0);
   endtask

   task automatic t_reset();
      rst_n = 0; step(2); rst_n = 1; step();
      chk("R1 state", seq_state, 0);
      chk("R1 outputs", {run, hold, rw_drive, cont_clr, gap_win, dport_err}, 0);
   endtask

   task automatic t_write_pause();
      start_xfer(0);
      chk("R2 state", seq_state, 1);
      chk("R2 run", run, 1);
      stop_req = 1; step(3);
      chk("R3 no midblock stop", seq_state, 1);
      blk_done = 1; step(); blk_done = 0;
      chk("R4 gap state", seq_state, 2);
      chk("R4 hold/run/rw", {hold, run, rw_drive}, 3'b100);
      cont_req = 1; step();
      chk("R7 continue ignored under stop", seq_state, 2);
      stop_req = 0; step();
      chk("R7 resumed", seq_state, 1);
      wr_active = 1;
      step(SYNC);
      chk("R8 no early clear", cont_clr, 0);
      step();
      chk("R8 clear pulse", cont_clr, 1);
      cont_req = 0;
      step();
      chk("R8 single pulse", cont_clr, 0);
      step(3);
      chk("R8 no repeat", cont_clr, 0);
      wr_active = 0;
      finish_xfer();
   endtask

   task automatic t_read_wait();
      rdwait_en = 1;
      start_xfer(1);
      stop_req = 1; blk_done = 1; step(); blk_done = 0;
      chk("R5 read wait state", seq_state, 3);
      chk("R5 rw_drive", rw_drive, 1);
      step(2);
      chk("R5 held", rw_drive, 1);
      stop_req = 0; cont_req = 1; step();
      chk("R7 read resumed", seq_state, 1);
      chk("R7 rw released", rw_drive, 0);
      dat_active = 1;
      step(SYNC + 1);
      chk("R8 clear on DAT active", cont_clr, 1);
      cont_req = 0; dat_active = 0;
      step();
      finish_xfer();
      rdwait_en = 0;
   endtask

   task automatic t_read_no_rw();
      start_xfer(1);
      stop_req = 1; blk_done = 1; step(); blk_done = 0;
      chk("R6 stop ignored on read", seq_state, 1);
      chk("R6 rw low", rw_drive, 0);
      blk_done = 1; xfer_done = 1; step(); blk_done = 0; xfer_done = 0;
      chk("R11 done beats block end", seq_state, 4);
      stop_req = 0;
      step();
   endtask

   task automatic t_gap_window();
      gapirq_en = 1; wide_bus = 1;
      start_xfer(0);
      blk_done = 1; step(); blk_done = 0;
      chk("R9 window open", gap_win, 1);
      step(WIN - 1);
      chk("R9 window last cycle", gap_win, 1);
      step();
      chk("R9 window closed", gap_win, 0);
      wide_bus = 0;
      blk_done = 1; step(); blk_done = 0;
      chk("R9 1-bit mode no window", gap_win, 0);
      wide_bus = 1; step(WIN);
      stop_req = 1; blk_done = 1; step(); blk_done = 0;
      step(WIN + 2);
      chk("R9 window during pause", gap_win, 1);
      stop_req = 0;
      finish_xfer();
      gapirq_en = 0; wide_bus = 0;
   endtask

   task automatic t_port_err();
      stop_req = 1; dport_wr = 1; step(); dport_wr = 0;
      chk("R10 error raised", dport_err, 1);
      step();
      chk("R10 error one cycle", dport_err, 0);
      stop_req = 0; dport_wr = 1; step(); dport_wr = 0;
      chk("R10 no error without stop", dport_err, 0);
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_write_pause();
      t_read_wait();
      t_read_no_rw();
      t_gap_window();
      t_port_err();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule